// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

The block is a small register whose stored word is either loaded, shifted by one place or held on each rising clock edge. A two-bit mode input makes the choice. A load copies a parallel word. A right shift moves every bit one place toward the least significant end and fills the top bit from a dedicated serial input. A left shift moves every bit one place toward the most significant end and fills the bottom bit from a second serial input. The fourth mode freezes the register.

The freeze is an enable on the data path of the flip-flops, and the clock itself is never gated. A synchronous active-high reset clears the register and overrides every mode. The stored word drives the output directly from the flip-flops, so the output carries no extra latency and has no combinational path from any input. All pins are plain control or data pins. The block has no handshake, because it accepts a new operation on every edge and never stalls. The width is a parameter with a default of 4.

Top module: `usr_top`

## Requirements
- R1: When `rst` is 1 at a rising edge, `q` becomes all zeros after that edge, whatever the values of `mode`, `par_d` and the serial inputs.
- R2: With `mode` = 2'b00 (load), `q` takes the value of `par_d` at the edge.
- R3: With `mode` = 2'b01 (shift right), `q` becomes `{ser_right_in, q[W-1:1]}`, so the old bit 0 is dropped.
- R4: With `mode` = 2'b10 (shift left), `q` becomes `{q[W-2:0], ser_left_in}`, so the old bit W-1 is dropped.
- R5: With `mode` = 2'b11 (hold), `q` keeps its value, and `par_d`, `ser_right_in` and `ser_left_in` have no effect on it.
- R6: `q` changes only at rising clock edges. A change on `mode`, `par_d` or either serial input between edges leaves `q` unchanged until the next edge.
- R7: A right shift ignores `ser_left_in` and `par_d`. A left shift ignores `ser_right_in` and `par_d`.
- R8: After W right shifts, `q` holds the serial bits that were shifted in, with the first bit in at bit 0 and the last bit in at bit W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, never gated |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | 00 load, 01 shift right, 10 shift left, 11 hold |
| par_d | input | W | Word captured by a load |
| ser_right_in | input | 1 | Bit that enters the MSB on a right shift |
| ser_left_in | input | 1 | Bit that enters the LSB on a left shift |
| q | output | W | Current register contents |

## Verification
Reset and a mode operation can fall in the same edge. Reset must win. The bench first loads a non-zero word, then raises `rst` while each of the four modes is selected, with the parallel and serial inputs set so that any mode that leaked through would give a non-zero result. The outcome is judged by requiring `q` to be zero right after that edge. Separately, every mode is swept over every start value, parallel word and serial pair, and the result is compared with shift and mask arithmetic computed in the bench.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_HOLD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next_state.sv
module usr_next_state
  import usr_pkg::*;
#(
  parameter int W = 4
) (
  input  usr_mode_e      mode_sel,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   par_d,
  input  logic           ser_right_in,
  input  logic           ser_left_in,
  output logic [W-1:0]   nxt,
  output logic           upd
);
  // Per-bit source selection: each bit sees its upper and lower neighbour.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_upper;
    logic from_lower;
    if (i == W - 1) begin : g_top
      assign from_upper = ser_right_in;
    end else begin : g_mid_u
      assign from_upper = cur[i+1];
    end
    if (i == 0) begin : g_bot
      assign from_lower = ser_left_in;
    end else begin : g_mid_l
      assign from_lower = cur[i-1];
    end
    always_comb begin
      unique case (mode_sel)
        MODE_LOAD: nxt[i] = par_d[i];
        MODE_SHR:  nxt[i] = from_upper;
        MODE_SHL:  nxt[i] = from_lower;
        default:   nxt[i] = cur[i];
      endcase
    end
  end

  assign upd = (mode_sel != MODE_HOLD);
endmodule

// File: rtl/usr_store.sv
module usr_store #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> q == '0)
    else $error("reset did not clear register");

  // R5
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> q == $past(q))
    else $error("register changed while disabled");
endmodule

// File: rtl/usr_top.sv
module usr_top
  import usr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [W-1:0] par_d,
  input  logic         ser_right_in,
  input  logic         ser_left_in,
  output logic [W-1:0] q
);
  usr_mode_e    mode_e;
  logic [W-1:0] nxt;
  logic         upd;

  assign mode_e = usr_mode_e'(mode);

  usr_next_state #(.W(W)) u_next (
    .mode_sel     (mode_e),
    .cur          (q),
    .par_d        (par_d),
    .ser_right_in (ser_right_in),
    .ser_left_in  (ser_left_in),
    .nxt          (nxt),
    .upd          (upd)
  );

  usr_store #(.W(W)) u_store (
    .clk (clk),
    .rst (rst),
    .en  (upd),
    .d   (nxt),
    .q   (q)
  );

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> q == $past(par_d))
    else $error("load mismatch");

  // R3
  shift_right_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |=> q == {$past(ser_right_in), $past(q[W-1:1])})
    else $error("right shift mismatch");

  // R4
  shift_left_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b10 |=> q == {$past(q[W-2:0]), $past(ser_left_in)})
    else $error("left shift mismatch");
endmodule

// File: tb/tb_usr_top.sv
`timescale 1ns/1ps
module tb_usr_top;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic [W-1:0] par_d;
  logic         ser_right_in;
  logic         ser_left_in;
  logic [W-1:0] q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  usr_top #(.W(W)) dut (
    .clk(clk), .rst(rst), .mode(mode), .par_d(par_d),
    .ser_right_in(ser_right_in), .ser_left_in(ser_left_in), .q(q)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: q=%0d expected %0d", req, act, exp);
    end
  endtask

  // Apply inputs at the falling edge, then sample 1 ns after the rising edge.
  task automatic step(input bit r, input int md, input int pd, input bit sr, input bit sl);
    @(negedge clk);
    rst = r; mode = md[1:0]; par_d = pd[W-1:0];
    ser_right_in = sr; ser_left_in = sl;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1; mode = 2'b00; par_d = '0; ser_right_in = 1'b0; ser_left_in = 1'b0;
    step(1, 0, 9, 1, 1);
    check("R1 reset state", q, 0);

    // Exhaustive sweep: start value x mode x par_d x serial pair.
    for (int s = 0; s <= M; s++)
      for (int md = 0; md < 4; md++)
        for (int pd = 0; pd <= M; pd++)
          for (int sp = 0; sp < 4; sp++) begin
            bit sr = sp[0];
            bit sl = sp[1];
            int exp;
            step(0, 0, s, 0, 0);
            step(0, md, pd, sr, sl);
            case (md)
              0: begin exp = pd; check("R2 load", q, exp); end
              1: begin exp = (s >> 1) | (int'(sr) << (W-1));
                 check("R3/R7 shift right", q, exp); end
              2: begin exp = ((s << 1) & M) | int'(sl);
                 check("R4/R7 shift left", q, exp); end
              default: begin exp = s; check("R5 hold", q, exp); end
            endcase
          end

    // R1: reset in the same edge as each mode, with hostile inputs.
    for (int md = 0; md < 4; md++) begin
      step(0, 0, M, 0, 0);
      step(1, md, M, 1, 1);
      check("R1 reset over mode", q, 0);
    end

    // R6: inputs change mid-cycle; q must not move before the edge.
    step(0, 0, 5, 0, 0);
    step(0, 3, 5, 0, 0);
    @(negedge clk);
    mode = 2'b00; par_d = 4'hA; ser_right_in = 1'b1; ser_left_in = 1'b1;
    #2;
    check("R6 no change between edges", q, 5);
    @(posedge clk); #1;
    check("R6 update at edge", q, 10);

    // R8: four right shifts replace the word with the serial stream.
    step(0, 0, 0, 0, 0);
    step(0, 1, 15, 1, 0);
    step(0, 1, 15, 0, 1);
    step(0, 1, 15, 1, 0);
    step(0, 1, 15, 1, 1);
    check("R8 serial fill", q, 4'b1101);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: q=%0d expected %0d", q, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule